// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Group Direction Control

This block drives and samples 64 general-purpose lines arranged as eight banks of eight. Line n lives in bank n/8 at bit n%8. Software reaches the block through two ports. A small configuration-register port holds the direction byte of every bank, plus a function-select byte for the lower banks. An I/O-mapped data window, placed at a base address supplied by the surrounding logic, gives one byte per bank.

Writing a data byte loads the bank's output latch. Reading a data byte returns the synchronised levels present on the pins, not the latch contents, so software changes one line by reading the byte, modifying it and writing it back. A line is driven only when its direction bit selects output and its bank has selected the simple-I/O function for that bit. Banks without a function-select byte always count as simple I/O.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit, every function-select bit and every output latch bit is 0, so `pin_oe` and `pin_out` are all zero.
- R2: The direction byte of bank g is written and read back at configuration address 0xC8+g (g = 0..7). In that byte, bit b = 1 makes line 8g+b an output and bit b = 0 makes it an input.
- R3: The function-select bytes of banks 0 to 4 are written and read back at configuration addresses 0xC0 to 0xC4. Addresses 0xC5 to 0xC7 read 0x00 and ignore writes.
- R4: Every configuration address outside 0xC0–0xC4 and 0xC8–0xCF reads 0x00. A write to such an address changes no register, which shows at `pin_oe` and `pin_out` and in the read-back of the mapped registers.
- R5: `io_hit` is high exactly when `io_rd` or `io_wr` is high and `io_addr` lies in `io_base` .. `io_base`+7.
- R6: An I/O write to `io_base`+g loads the output latch of bank g, which appears on `pin_out[8g+7:8g]` after the clock edge. I/O writes outside the window change no latch.
- R7: An I/O read at `io_base`+g returns `pin_in[8g+7:8g]` as sampled through a two-flop synchroniser. A level applied before a rising edge is not visible after that first edge and is visible after the second. A read outside the window returns 0x00.
- R8: `pin_oe[n]` is the direction bit of line n ANDed with its function-select bit for banks 0 to 4, and equals the direction bit alone for banks 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational on cfg_addr) |
| io_base | input | 16 | Base address of the 8-byte data window |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, synchronised pin levels |
| io_hit | output | 1 | Access claimed by this block |
| pin_in | input | 64 | Sampled pin levels |
| pin_out | output | 64 | Output latch values |
| pin_oe | output | 64 | Per-line drive enable |

## Verification
The bench goes after the edges of the decoded spaces.

- At 0xC4/0xC5 and 0xC7/0xC8, an off-by-one decode would store a function-select byte for bank 5 or lose the one for bank 4.
- At the window edges, with the base placed at 0xFFF8, a design that let the offset wrap would claim address 0x0000.

The bench also checks the gating of `pin_oe` by the function-select bits only on the lower banks. A design that gated every bank would leave banks 5–7 undriven, and one that gated none would drive lines whose function is deselected.

Read-back of pins whose values loop back from driven outputs shows whether a read returns the latch instead of the pin. A single-edge probe of the synchroniser exposes a missing or extra stage.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int          GROUPS     = 8,
  parameter int          LANE       = 8,
  parameter int          SIO_GROUPS = 5,
  parameter int          AW         = 16,
  parameter logic [7:0]  SIO_BASE   = 8'hC0,
  parameter logic [7:0]  OE_BASE    = 8'hC8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [7:0]               cfg_addr,
  input  logic [7:0]               cfg_wdata,
  output logic [7:0]               cfg_rdata,
  input  logic [AW-1:0]            io_base,
  input  logic                     io_rd,
  input  logic                     io_wr,
  input  logic [AW-1:0]            io_addr,
  input  logic [LANE-1:0]          io_wdata,
  output logic [LANE-1:0]          io_rdata,
  output logic                     io_hit,
  input  logic [GROUPS*LANE-1:0]   pin_in,
  output logic [GROUPS*LANE-1:0]   pin_out,
  output logic [GROUPS*LANE-1:0]   pin_oe
);
  localparam int LINES = GROUPS * LANE;
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [AW-1:0] WIN  = AW'(GROUPS);
  localparam logic [7:0]    NOE  = 8'(GROUPS);
  localparam logic [7:0]    NSIO = 8'(SIO_GROUPS);

  logic [7:0]    oe_off, sio_off;
  logic          oe_sel, sio_sel;
  logic [AW-1:0] io_off;
  logic          in_win;
  logic [GW-1:0] io_grp;
  logic [LINES-1:0] sync1, sync2;

  logic [GROUPS-1:0][LANE-1:0] oe_v, sio_v, lat_v;

  assign oe_off  = cfg_addr - OE_BASE;
  assign sio_off = cfg_addr - SIO_BASE;
  assign oe_sel  = oe_off < NOE;
  assign sio_sel = sio_off < NSIO;

  assign io_off  = io_addr - io_base;
  assign in_win  = io_off < WIN;
  assign io_grp  = io_off[GW-1:0];
  assign io_hit  = in_win & (io_rd | io_wr);

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    logic [LANE-1:0] oe_r, lat_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_r  <= '0;
        lat_r <= '0;
      end else begin
        if (cfg_wr && oe_sel && oe_off[GW-1:0] == GW'(g))
          oe_r <= cfg_wdata[LANE-1:0];
        if (io_wr && in_win && io_grp == GW'(g))
          lat_r <= io_wdata;
      end
    end

    if (g < SIO_GROUPS) begin : g_sio
      logic [LANE-1:0] sio_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sio_r <= '0;
        else if (cfg_wr && sio_sel && sio_off[GW-1:0] == GW'(g))
          sio_r <= cfg_wdata[LANE-1:0];
      end
      assign sio_v[g] = sio_r;
    end else begin : g_fixed
      assign sio_v[g] = '1;
    end

    assign oe_v[g]  = oe_r;
    assign lat_v[g] = lat_r;
    assign pin_oe[g*LANE +: LANE]  = oe_r & sio_v[g];
    assign pin_out[g*LANE +: LANE] = lat_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (oe_sel)
      cfg_rdata = 8'(oe_v[oe_off[GW-1:0]]);
    else if (sio_sel)
      cfg_rdata = 8'(sio_v[sio_off[GW-1:0]]);
  end

  assign io_rdata = (io_rd && in_win) ? sync2[io_grp*LANE +: LANE] : '0;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int          GROUPS     = 8,
  parameter int          LANE       = 8,
  parameter int          SIO_GROUPS = 5,
  parameter int          AW         = 16,
  parameter logic [7:0]  SIO_BASE   = 8'hC0,
  parameter logic [7:0]  OE_BASE    = 8'hC8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr,
  input logic [7:0]             cfg_addr,
  input logic [7:0]             cfg_wdata,
  input logic [7:0]             cfg_rdata,
  input logic [AW-1:0]          io_base,
  input logic                   io_rd,
  input logic                   io_wr,
  input logic [AW-1:0]          io_addr,
  input logic [LANE-1:0]        io_wdata,
  input logic                   io_hit,
  input logic [GROUPS*LANE-1:0] pin_out,
  input logic [GROUPS*LANE-1:0] pin_oe
);
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  logic [AW-1:0] off;
  logic          unmapped;
  assign off = io_addr - io_base;
  assign unmapped = !((cfg_addr >= SIO_BASE && cfg_addr < SIO_BASE + 8'(SIO_GROUPS)) ||
                      (cfg_addr >= OE_BASE  && cfg_addr < OE_BASE  + 8'(GROUPS)));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0));

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> cfg_rdata == 8'h00);

  a_r4_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && unmapped && !io_wr) |=> ($stable(pin_oe) && $stable(pin_out)));

  a_r5_base_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_addr == io_base) |-> io_hit);

  a_r6_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_hit) |=> $stable(pin_out));

  a_r6_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_hit) |=> pin_out[$past(off[GW-1:0])*LANE +: LANE] == $past(io_wdata));

  a_r8_upper_ungated: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OE_BASE + 8'(GROUPS-1)) |=>
      pin_oe[GROUPS*LANE-1 -: LANE] == $past(cfg_wdata[LANE-1:0]));
endmodule

bind gpio_bank gpio_bank_chk #(
  .GROUPS(GROUPS), .LANE(LANE), .SIO_GROUPS(SIO_GROUPS), .AW(AW),
  .SIO_BASE(SIO_BASE), .OE_BASE(OE_BASE)
) u_chk (.*);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [15:0] io_base = 16'h0A00;
  logic        io_rd = 0, io_wr = 0, io_hit;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0, io_rdata;
  logic [63:0] pin_in, pin_out, pin_oe, ext = 0;

  int checks = 0, errors = 0;
  logic [7:0] m_oe[8], m_sio[8], m_lat[8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_bank u_dut (.*);

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] e_oe();
    logic [63:0] r;
    for (int g = 0; g < 8; g++) r[g*8 +: 8] = m_oe[g] & m_sio[g];
    return r;
  endfunction

  function automatic logic [63:0] e_out();
    logic [63:0] r;
    for (int g = 0; g < 8; g++) r[g*8 +: 8] = m_lat[g];
    return r;
  endfunction

  function automatic logic [7:0] e_cfg(logic [7:0] a);
    if (a >= 8'hC8 && a <= 8'hCF) return m_oe[a - 8'hC8];
    if (a >= 8'hC0 && a <= 8'hC4) return m_sio[a - 8'hC0];
    return 8'h00;
  endfunction

  function automatic logic [63:0] e_lvl();
    return (e_oe() & e_out()) | (~e_oe() & ext);
  endfunction

  function automatic logic in_win(logic [15:0] a);
    logic [15:0] d;
    d = a - io_base;
    return d < 16'd8;
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 8; g++) begin
      m_oe[g] = 0; m_lat[g] = 0; m_sio[g] = (g < 5) ? 8'h00 : 8'hFF;
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (a >= 8'hC8 && a <= 8'hCF) m_oe[a - 8'hC8] = d;
    else if (a >= 8'hC0 && a <= 8'hC4) m_sio[a - 8'hC0] = d;
    #1;
    check("R8 pin_oe", pin_oe, e_oe());
    check("R4 pin_out", pin_out, e_out());
  endtask

  task automatic cfg_read(string tag, logic [7:0] a);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, {56'd0, cfg_rdata}, {56'd0, e_cfg(a)});
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_addr = a; io_wdata = d;
    #1;
    check("R5 hit on write", {63'd0, io_hit}, {63'd0, in_win(a)});
    @(negedge clk);
    io_wr = 0;
    if (in_win(a)) m_lat[a - io_base] = d;
    #1;
    check("R6 pin_out", pin_out, e_out());
  endtask

  task automatic io_read(string tag, logic [15:0] a, int settle);
    logic [63:0] l;
    repeat (settle) @(negedge clk);
    io_rd = 1; io_addr = a;
    #1;
    l = e_lvl();
    check("R5 hit on read", {63'd0, io_hit}, {63'd0, in_win(a)});
    check(tag, {56'd0, io_rdata}, in_win(a) ? {56'd0, l[(a - io_base)*8 +: 8]} : 64'd0);
    @(negedge clk);
    io_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 pin_oe reset", pin_oe, 64'd0);
    check("R1 pin_out reset", pin_out, 64'd0);
    rst_n = 1;
    cfg_read("R1 oe reg reset", 8'hC8);
    cfg_read("R1 sio reg reset", 8'hC0);

    // R2 direction bytes, R8 gating on lower banks
    for (int g = 0; g < 8; g++) cfg_write(8'hC8 + 8'(g), 8'hA5 ^ 8'(g));
    for (int g = 0; g < 8; g++) cfg_read("R2 oe readback", 8'hC8 + 8'(g));
    check("R8 lower gated, upper free", pin_oe, e_oe());
    // R3 function select edges
    cfg_write(8'hC4, 8'h3C);
    cfg_read("R3 sio bank4", 8'hC4);
    cfg_write(8'hC5, 8'hFF);
    cfg_read("R3 C5 reads zero", 8'hC5);
    cfg_write(8'hC7, 8'hFF);
    cfg_read("R3 C7 reads zero", 8'hC7);
    cfg_read("R2 C8 intact", 8'hC8);
    // R4 unmapped
    cfg_write(8'hBF, 8'hFF);
    cfg_write(8'hD0, 8'hFF);
    cfg_read("R4 BF zero", 8'hBF);
    cfg_read("R4 D0 zero", 8'hD0);
    cfg_read("R4 C4 intact", 8'hC4);

    // R6 / R7 loopback through driven outputs
    for (int g = 0; g < 5; g++) cfg_write(8'hC0 + 8'(g), 8'hFF);
    for (int g = 0; g < 8; g++) cfg_write(8'hC8 + 8'(g), 8'hF0);
    ext = 64'h0123_4567_89AB_CDEF;
    for (int g = 0; g < 8; g++) io_write(io_base + 16'(g), 8'h5A + 8'(g));
    for (int g = 0; g < 8; g++) io_read("R7 mixed levels", io_base + 16'(g), 3);
    io_write(io_base + 16'd8, 8'hFF);
    io_write(io_base - 16'd1, 8'hFF);
    io_read("R7 outside reads zero", io_base + 16'd8, 1);

    // R7 synchroniser depth on bank 0 inputs
    cfg_write(8'hC8, 8'h00);
    @(negedge clk); ext[7:0] = 8'h00;
    repeat (3) @(negedge clk);
    ext[7:0] = 8'hC3;
    io_rd = 1; io_addr = io_base;
    @(negedge clk); #1;
    check("R7 one edge old", {56'd0, io_rdata}, 64'h00);
    @(negedge clk); #1;
    check("R7 two edges new", {56'd0, io_rdata}, 64'hC3);
    io_rd = 0;

    // R5 window at top of address space
    io_base = 16'hFFF8;
    io_write(16'hFFFF, 8'h77);
    io_write(16'h0000, 8'h11);
    io_read("R5 top window", 16'hFFF8, 3);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      op = $urandom_range(0, 5);
      if (i % 50 == 0) io_base = 16'($urandom_range(0, 16'hFFFF));
      case (op)
        0: cfg_write(8'hC0 + 8'($urandom_range(0, 15)), 8'($urandom));
        1: cfg_read("R2 R3 R4 random cfg read", 8'($urandom_range(8'hB8, 8'hD8)));
        2: io_write(io_base + 16'($urandom_range(0, 11)) - 16'd2, 8'($urandom));
        3: io_read("R7 random read", io_base + 16'($urandom_range(0, 11)) - 16'd2, 3);
        4: begin @(negedge clk); ext = {$urandom, $urandom}; end
        default: cfg_write(8'($urandom), 8'($urandom));
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule